// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates sixteen interrupt sources for a small 8-bit microcontroller core. Each source owns a pending flag. A peripheral pulse sets the flag, and software can also set or clear it through a small register port. Per-source enable bits, per-source priority bits and one global enable decide which pending flags may raise a request. The controller presents one request to the CPU, together with the chosen source index and that source's fixed call address.

A decision is made only when the CPU signals an instruction boundary. The decision uses the register state from before any write in that same cycle. Once posted, the request holds until the CPU acknowledges it. The acknowledge marks the request's priority level as in service, and for a chosen subset of sources it also clears the pending flag. A return strobe releases the innermost level. A high-priority request may interrupt a low-priority handler. No handler is interrupted by a request of its own level or a lower one.

Top module: `irq_ctrl_top`

## Requirements
- R1: There are 16 sources. The request carries the source index on `irq_src` and the call address 0x0003 + 8*index on `irq_vec`.
- R2: A peripheral pulse on `hw_set[n]` sets pending flag n whether or not source n is enabled. A flag whose enable bit is 0 never raises a request.
- R3: A request is posted only when the global enable is 1 and the source's own enable bit is 1. With the global enable at 0, no request is posted whatever the individual enables hold.
- R4: A flag that becomes pending while the global enable is 0 stays pending. It is serviced at the first instruction boundary after the global enable returns to 1.
- R5: A request is posted only in the cycle after `insn_done` is 1. It then stays up, with the same index and address, until `irq_ack` is 1.
- R6: On acknowledge, the pending flag of the served source is cleared if its bit in parameter AUTO_CLR is 1 (by default sources 0 and 2). Every other flag stays set until software writes it to 0.
- R7: If a pending flag is still set after the return strobe `irq_ret`, a new request for that flag is posted at the next instruction boundary.
- R8: Writing 1 to a pending flag through the register port raises a request exactly as a peripheral pulse does.
- R9: A write that clears an enable, in the same cycle as `insn_done`, does not stop that boundary's decision. The request is posted even though the enable then reads back as 0.
- R10: A source whose priority bit is 1 (high) wins over every low source. Within one level, the lowest index wins.
- R11: Acknowledge marks the request's level in service. A high request may preempt a low handler. Nothing is posted while a handler of the same or a higher level is in service. `irq_ret` clears the high in-service bit if it is set, and otherwise the low one.
- R12: A peripheral pulse in the same cycle as a software write of 0 to that flag leaves the flag set.
- R13: The register port (`reg_addr`) holds four registers: 0 pending flags, 1 enables, 2 priorities, 3 control. In the control register, bit 0 is the global enable (the only bit that can be written), bit 1 reads the low in-service state and bit 2 reads the high in-service state. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_set | input | 16 | Peripheral pulses that set pending flags |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_ack | input | 1 | CPU takes the posted request |
| irq_ret | input | 1 | CPU finished a handler |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_src | output | 4 | Index of the requested source |
| irq_vec | output | 16 | Call address of the requested source |

## Verification
A wrong in-service bit shows up as a request that is posted or withheld at the next instruction boundary: either a preemption the nesting rule forbids, or a source that never gets served. The control register also shows the bit as soon as it is read. A corrupted pending flag shows in the pending register on the very next read. It also shows as a missing request, or an extra one, at the following boundary. A wrong arbitration result appears one cycle after the boundary, as an index or address on `irq_src` and `irq_vec` that differs from the one the scoreboard queued.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_EN   = 2'd1,
    RA_PRIO = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  localparam logic [15:0] VEC_BASE   = 16'h0003;
  localparam int unsigned VEC_STRIDE = 8;

  // call address for a source index
  function automatic logic [15:0] vec_of(input int unsigned idx);
    return VEC_BASE + 16'(idx * VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 16,
  parameter logic [N-1:0] AUTO_CLR = 'h5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         sw_we,
  input  logic [N-1:0] sw_data,
  input  logic [N-1:0] ack_hot,
  output logic [N-1:0] pend
);
  logic [N-1:0] self_clr;
  logic [N-1:0] pend_nxt;

  assign self_clr = ack_hot & AUTO_CLR;

  always_comb begin
    pend_nxt = sw_we ? sw_data : pend;
    pend_nxt = pend_nxt & ~self_clr;
    pend_nxt = pend_nxt | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set))); // R12
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((self_clr & ~hw_set) != '0) |=> ((pend & $past(self_clr & ~hw_set)) == '0)); // R6
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  prio,
  input  logic          gie,
  input  logic [1:0]    ins,
  output logic          hit,
  output logic          lvl,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  elig [2];
  logic [IW-1:0] low_idx [2];

  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = IW'(i);
  endfunction

  // level 0 needs nothing in service, level 1 needs the high level idle
  assign elig[0] = pend & en & ~prio & {N{gie && (ins == 2'b00)}};
  assign elig[1] = pend & en &  prio & {N{gie && !ins[1]}};

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    assign low_idx[g] = lowest(elig[g]);
  end

  assign lvl = |elig[1];
  assign hit = lvl || (|elig[0]);
  assign idx = lvl ? low_idx[1] : low_idx[0];
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mark,
  input  logic       mark_lvl,
  input  logic       ret,
  output logic [1:0] ins
);
  logic [1:0] ins_nxt;

  always_comb begin
    ins_nxt = ins;
    if (ret) begin
      if (ins_nxt[1]) ins_nxt[1] = 1'b0;
      else            ins_nxt[0] = 1'b0;
    end
    if (mark) ins_nxt[mark_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins <= '0;
    else        ins <= ins_nxt;
  end

  AST_MARK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> ins[$past(mark_lvl)]); // R11
  AST_RET_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !mark && ins != 2'b00) |=> ($countones(ins) == $countones($past(ins)) - 1)); // R11
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int N_SRC = 16,
  parameter logic [N_SRC-1:0] AUTO_CLR = 'h5,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_set,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic             insn_done,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [IW-1:0]    irq_src,
  output logic [15:0]      irq_vec
);
  import irq_pkg::*;

  logic [N_SRC-1:0] en_q, prio_q, pend, ack_hot;
  logic             gie_q;
  logic [1:0]       ins;
  logic             req_q, lvl_q;
  logic [IW-1:0]    src_q;
  logic             pick_hit, pick_lvl;
  logic [IW-1:0]    pick_idx;
  logic             ack_take, post, wr_pend;
  reg_addr_e        ra;

  assign ra       = reg_addr_e'(reg_addr);
  assign wr_pend  = reg_we && (ra == RA_PEND);
  assign ack_take = irq_ack && req_q;
  assign post     = insn_done && !req_q && pick_hit;
  assign ack_hot  = ack_take ? (N_SRC'(1) << src_q) : '0;

  irq_pend_bank #(.N(N_SRC), .AUTO_CLR(AUTO_CLR)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_we(wr_pend),
    .sw_data(reg_wdata), .ack_hot(ack_hot), .pend(pend)
  );

  irq_pick #(.N(N_SRC)) u_pick (
    .pend(pend), .en(en_q), .prio(prio_q), .gie(gie_q), .ins(ins),
    .hit(pick_hit), .lvl(pick_lvl), .idx(pick_idx)
  );

  irq_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .mark(ack_take), .mark_lvl(lvl_q),
    .ret(irq_ret), .ins(ins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; prio_q <= '0; gie_q <= 1'b0;
    end else if (reg_we) begin
      case (ra)
        RA_EN:   en_q   <= reg_wdata;
        RA_PRIO: prio_q <= reg_wdata;
        RA_CTRL: gie_q  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; src_q <= '0; lvl_q <= LVL_LO;
    end else if (post) begin
      req_q <= 1'b1; src_q <= pick_idx; lvl_q <= pick_lvl;
    end else if (ack_take) begin
      req_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (ra)
      RA_PEND: reg_rdata = pend;
      RA_EN:   reg_rdata = en_q;
      RA_PRIO: reg_rdata = prio_q;
      default: begin
        reg_rdata[0]   = gie_q;
        reg_rdata[2:1] = ins;
      end
    endcase
  end

  assign irq_req = req_q;
  assign irq_src = src_q;
  assign irq_vec = vec_of(32'(src_q));

  AST_POST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_done)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_src))); // R5
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(gie_q)); // R3
  AST_NO_POST_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !$past(ins[1])); // R11
  AST_PREEMPT_IS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && $past(ins != 2'b00)) |-> (lvl_q == LVL_HI)); // R11
endmodule

// File: tb/irq_ctrl_top_bench.sv
module irq_ctrl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_set = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        insn_done = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_src;
  logic [15:0] irq_vec;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit seen = 1'b0;

  localparam logic [1:0] A_PEND = 2'd0, A_EN = 2'd1, A_PRIO = 2'd2, A_CTRL = 2'd3;

  always #5 clk = ~clk;

  irq_ctrl_top u_irq_ctrl_top (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_done(insn_done),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_src(irq_src),
    .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each new request is compared with the queued source
  always @(negedge clk) begin
    if (rst_n && irq_req && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected request", irq_src, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(irq_src == 4'(e), "R10 source index", irq_src, e);
        chk(irq_vec == 16'((e << 3) + 3), "R1 call address", irq_vec, (e << 3) + 3);
      end
    end else if (!irq_req) seen = 1'b0;
  end

  task automatic push(input int n); exp_q.push_back(n); endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == 16'(exp), tag, reg_rdata, exp);
  endtask

  task automatic boundary();
    @(negedge clk); insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
  endtask
  task automatic ack();
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask
  task automatic ret();
    @(negedge clk); irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
  endtask
  task automatic hw(input logic [15:0] m);
    @(negedge clk); hw_set = m; @(negedge clk); hw_set = '0;
  endtask
  task automatic no_req(input string tag);
    chk(irq_req == 1'b0, tag, irq_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    no_req("R13 reset request");
    rd(A_PEND, 0, "R13 reset pend"); rd(A_EN, 0, "R13 reset en");
    rd(A_PRIO, 0, "R13 reset prio"); rd(A_CTRL, 0, "R13 reset ctrl");

    // R2: latch while disabled, no request
    hw(16'h0020); rd(A_PEND, 'h20, "R2 latched while disabled");
    boundary(); no_req("R2 disabled flag requested");
    // R3 / R4: global enable gates, pending survives
    wr(A_EN, 16'h0020); boundary(); no_req("R3 global enable off");
    wr(A_CTRL, 16'h0001); push(5); boundary();
    chk(irq_req, "R4 held flag served", irq_req, 1);
    ack(); rd(A_CTRL, 'b011, "R11 low in service");
    rd(A_PEND, 'h20, "R6 flag kept without auto clear");
    boundary(); no_req("R11 same level preempted");
    // R7: retrigger after return
    ret(); rd(A_CTRL, 'b001, "R11 return clears low");
    push(5); boundary(); chk(irq_req, "R7 retrigger", irq_req, 1);
    ack(); wr(A_PEND, 16'h0000); ret(); boundary(); no_req("R7 cleared flag retriggered");

    // R10 / R11: same level lowest index, then high preempts low
    wr(A_EN, 16'h0228); hw(16'h0208); push(3); boundary(); ack();
    wr(A_PEND, 16'h0200); wr(A_PRIO, 16'h0200); push(9); boundary();
    chk(irq_req, "R11 high preempts low", irq_req, 1);
    ack(); rd(A_CTRL, 'b111, "R11 both levels in service");
    boundary(); no_req("R11 nothing preempts high");
    ret(); rd(A_CTRL, 'b011, "R11 return clears high first");
    ret(); rd(A_CTRL, 'b001, "R11 second return clears low");
    wr(A_PEND, 16'h0000);
    // R10: high wins over lower index
    wr(A_EN, 16'h0222); hw(16'h0202); push(9); boundary(); ack();
    wr(A_PEND, 16'h0002); ret(); push(1); boundary(); ack();
    wr(A_PEND, 16'h0000); ret();

    // R6: auto-clearing source 2
    wr(A_EN, 16'h0004); hw(16'h0004); push(2); boundary(); ack();
    rd(A_PEND, 0, "R6 auto clear on ack"); ret();
    // R8: software set
    wr(A_EN, 16'h0020); wr(A_PEND, 16'h0020); push(5); boundary();
    chk(irq_req, "R8 software set requests", irq_req, 1);
    ack(); wr(A_PEND, 16'h0000); ret();

    // R9: disable in the boundary cycle
    hw(16'h0020); push(5);
    @(negedge clk); reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = 16'h0000; insn_done = 1'b1;
    @(negedge clk); reg_we = 1'b0; insn_done = 1'b0;
    chk(irq_req, "R9 request despite disable", irq_req, 1);
    rd(A_CTRL, 0, "R9 enable reads 0");
    ack(); wr(A_PEND, 16'h0000); ret();
    hw(16'h0020); boundary(); no_req("R3 global off after R9");
    rd(A_PEND, 'h20, "R4 pending held while off"); wr(A_PEND, 16'h0000);

    // R12: hw set beats sw clear
    wr(A_PEND, 16'h0080);
    @(negedge clk); reg_we = 1'b1; reg_addr = A_PEND; reg_wdata = 16'h0000; hw_set = 16'h0080;
    @(negedge clk); reg_we = 1'b0; hw_set = '0;
    rd(A_PEND, 'h80, "R12 hw set wins");
    wr(A_PEND, 16'h0000); rd(A_PEND, 0, "R12 sw clear alone");

    // R1: extreme indices
    wr(A_CTRL, 16'h0001); wr(A_EN, 16'h8000); hw(16'h8000); push(15); boundary();
    ack(); wr(A_PEND, 16'h0000); ret();
    wr(A_EN, 16'h0001); hw(16'h0001); push(0); boundary(); ack();
    rd(A_PEND, 0, "R6 source 0 auto clear"); ret();

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all queued requests seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule